// File: doc/BRIEF.md
# Dual-Address Paged Byte Map with Layered Write Protection

This block sits behind a two-wire slave byte engine and turns each decoded access (7-bit device address, byte offset, direction, data) into a read or write of internal byte storage. It answers on two device addresses. The auxiliary address reaches a private 256-byte space. The primary address reaches a 128-byte lower page and, above offset 80h, one of several 128-byte upper pages. A page-select byte held in the lower page picks which one.

A configuration byte in upper page 01 holds four control bits. Two are protection bits. One moves the primary address to a programmable value. One switches the part to single-address operation, where an extra upper page 00 appears and the auxiliary address goes silent. A write-protect pin combines with the protection bits to lock storage. A lock never refuses the bus acknowledge. It only suppresses the store and raises a one-cycle flag. Storage is plain registers, cleared by reset.

Top module: `dual_addr_memmap`

## Requirements
- R1: The block acknowledges only device address 50h (auxiliary) and, by default, 51h (primary). Any other address gets no acknowledge, read data 00h, and a write to it changes nothing.
- R2: When configuration bit 3 (address-fixed) is 1, the primary address becomes bits [7:1] of upper page 01 byte 0Ch. 51h then gets no acknowledge.
- R3: Through the primary address, offsets 80h-FFh reach the page named by the byte at primary offset 7Fh. Value 01h selects page 01 and 02h selects page 02. Value 03h selects auxiliary bytes 00h-7Fh, at offset minus 80h.
- R4: The auxiliary address reaches all 256 auxiliary bytes directly, with no paging.
- R5: With an unmapped select value (04h-FFh, or 00h outside single-address mode), upper-half reads return FFh. Upper-half writes are acknowledged but change no storage.
- R6: When configuration bit 2 (single-address) is 1, select 00h reaches a separate page 00 and the auxiliary address gets no acknowledge.
- R7: Primary writes to offsets 00h-5Fh and to the upper pages (other than page 00 in single-address mode) are blocked exactly when the protect pin is 1 and configuration bit 0 (primary-protect) is 1.
- R8: Auxiliary-address writes are blocked exactly when configuration bit 1 (auxiliary-protect) is 1, at either pin level.
- R9: In single-address mode, writes to page 00 are blocked exactly when configuration bit 1 is 1. The pin has no effect on them.
- R10: Primary offsets 60h-7Fh are always writable.
- R11: A blocked write is acknowledged, leaves storage unchanged, and raises `wr_blocked` for exactly the one cycle after the write.
- R12: After reset, all storage, the configuration byte and the page select read 00h, and `wr_blocked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_dev_addr | input | 7 | Device address of the access |
| acc_offset | input | 8 | Byte offset |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write data |
| wp_pin | input | 1 | Write-protect pin |
| acc_ack | output | 1 | Address matched (combinational) |
| acc_rdata | output | 8 | Read data (combinational) |
| wr_blocked | output | 1 | Pulses the cycle after a blocked write |

## Verification
Every auxiliary byte is written through its own address with an arithmetic pattern, then read back twice. Once directly and once through the page-03 window, which separates correct paging from an offset that is off by one or mirrored. Pages 01 and 02 get different patterns at the same offsets, which exposes aliasing. An unmapped select shows that reads return FFh and writes leave the other pages alone. All 128 device addresses are swept, along with a moved primary address. All 16 combinations of pin, both protect bits and single-address mode are applied to one probe in each region (lower page, scratch, page 01, page 00, auxiliary). In every combination the expected block flag and read-back value are compared, so each protection rule is told apart from the others.

// File: rtl/mm_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the dual-address byte map.
// Assumes 8-bit bytes and 7-bit device addresses.
package mm_pkg;
    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;

    // configuration bit positions inside page 01 byte 09h (offset 89h)
    localparam int CFG_MAIN_PROT = 0;
    localparam int CFG_AUX_PROT  = 1;
    localparam int CFG_SINGLE    = 2;
    localparam int CFG_ADDR_FIX  = 3;

    localparam logic [7:0] IDX_PAGE_SEL = 8'h7F; // in lower page
    localparam logic [7:0] IDX_CFG      = 8'h09; // in page 01
    localparam logic [7:0] IDX_FIXADDR  = 8'h0C; // in page 01
    localparam logic [7:0] SCRATCH_LO   = 8'h60;

    localparam logic [7:0] SEL_PAGE00  = 8'h00;
    localparam logic [7:0] SEL_PAGE01  = 8'h01;
    localparam logic [7:0] SEL_PAGE02  = 8'h02;
    localparam logic [7:0] SEL_AUX_WIN = 8'h03;

    typedef enum logic [2:0] {
        BK_LOW  = 3'd0,
        BK_P00  = 3'd1,
        BK_P01  = 3'd2,
        BK_P02  = 3'd3,
        BK_AUX  = 3'd4,
        BK_NONE = 3'd7
    } bank_e;

    localparam int NUM_BANKS = 5;
endpackage

// File: rtl/mm_byte_bank.sv
`timescale 1ns/1ps
// Module: mm_byte_bank
// One byte-wide register array with a single address port. Reads are
// asynchronous; writes land on the clock edge. Reset clears every byte.
// Assumes DEPTH is a power of two.
module mm_byte_bank #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    // store one byte per enabled cycle, clear all on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    // asynchronous read of the addressed byte
    assign rdata = mem_q[addr];
endmodule

// File: rtl/mm_ctrl_regs.sv
`timescale 1ns/1ps
// Module: mm_ctrl_regs
// Keeps copies of the three control bytes (page select, configuration,
// programmable primary address) next to the decoder. It watches committed
// writes, so each copy always equals the byte in its storage bank.
// Assumes a write arrives only when the bank write is also committed.
module mm_ctrl_regs
    import mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  bank_e             wr_bank,
    input  logic [7:0]        wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] page_sel_q,
    output logic [BYTE_W-1:0] cfg_q,
    output logic [BYTE_W-1:0] fixaddr_q
);
    logic hit_sel, hit_cfg, hit_fix;

    // locate which control byte, if any, a committed write lands on
    always_comb begin
        hit_sel = commit && (wr_bank == BK_LOW) && (wr_idx == IDX_PAGE_SEL);
        hit_cfg = commit && (wr_bank == BK_P01) && (wr_idx == IDX_CFG);
        hit_fix = commit && (wr_bank == BK_P01) && (wr_idx == IDX_FIXADDR);
    end

    // update the control copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_sel_q <= '0;
            cfg_q      <= '0;
            fixaddr_q  <= '0;
        end else begin
            if (hit_sel) page_sel_q <= wr_data;
            if (hit_cfg) cfg_q      <= wr_data;
            if (hit_fix) fixaddr_q  <= wr_data;
        end
    end
endmodule

// File: rtl/mm_addr_decode.sv
`timescale 1ns/1ps
// Module: mm_addr_decode
// Purely combinational. Matches the device address, picks a storage bank and
// an index inside it, and evaluates the write lock for that target.
// Assumes the primary address takes precedence if it equals the auxiliary one.
module mm_addr_decode
    import mm_pkg::*;
#(
    parameter logic [DEV_W-1:0] AUX_ADDR       = 7'h50,
    parameter logic [DEV_W-1:0] MAIN_ADDR_DFLT = 7'h51
) (
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [7:0]        offset,
    input  logic [BYTE_W-1:0] cfg,
    input  logic [BYTE_W-1:0] fixaddr,
    input  logic [BYTE_W-1:0] page_sel,
    input  logic              wp_pin,
    output logic              hit_main,
    output logic              hit_aux,
    output bank_e             bank,
    output logic [7:0]        idx,
    output logic              locked,
    output logic              unmapped
);
    logic [DEV_W-1:0] main_addr;
    logic             single_mode;
    logic             main_lock;
    logic             aux_lock;

    // effective primary address, mode and lock terms
    always_comb begin
        main_addr   = cfg[CFG_ADDR_FIX] ? fixaddr[7:1] : MAIN_ADDR_DFLT;
        single_mode = cfg[CFG_SINGLE];
        main_lock   = wp_pin && cfg[CFG_MAIN_PROT];
        aux_lock    = cfg[CFG_AUX_PROT];
        hit_main    = (dev_addr == main_addr);
        hit_aux     = !hit_main && !single_mode && (dev_addr == AUX_ADDR);
    end

    // route the access to a bank and decide its lock
    always_comb begin
        bank     = BK_NONE;
        idx      = '0;
        locked   = 1'b0;
        unmapped = 1'b0;
        if (hit_aux) begin
            bank   = BK_AUX;
            idx    = offset;
            locked = aux_lock;
        end else if (hit_main) begin
            idx = {1'b0, offset[6:0]};
            if (!offset[7]) begin
                bank   = BK_LOW;
                locked = (offset < SCRATCH_LO) ? main_lock : 1'b0;
            end else begin
                unique case (page_sel)
                    SEL_PAGE00: begin
                        if (single_mode) begin
                            bank   = BK_P00;
                            locked = aux_lock;
                        end else begin
                            unmapped = 1'b1;
                        end
                    end
                    SEL_PAGE01: begin
                        bank   = BK_P01;
                        locked = main_lock;
                    end
                    SEL_PAGE02: begin
                        bank   = BK_P02;
                        locked = main_lock;
                    end
                    SEL_AUX_WIN: begin
                        bank   = BK_AUX;
                        locked = main_lock;
                    end
                    default: unmapped = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/dual_addr_memmap.sv
`timescale 1ns/1ps
// Module: dual_addr_memmap (top)
// Byte map behind a two-wire slave engine. It holds two device addresses,
// paged upper pages and layered write protection. Read data and the
// acknowledge are combinational for the presented access. A write commits on
// the clock edge, and a blocked write raises wr_blocked for the next cycle.
// Assumes at most one access per cycle, qualified by acc_valid.
module dual_addr_memmap
    import mm_pkg::*;
#(
    parameter logic [6:0] AUX_ADDR       = 7'h50,
    parameter logic [6:0] MAIN_ADDR_DFLT = 7'h51,
    parameter int         PAGE_DEPTH     = 128,
    parameter int         AUX_DEPTH      = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic [6:0] acc_dev_addr,
    input  logic [7:0] acc_offset,
    input  logic       acc_write,
    input  logic [7:0] acc_wdata,
    input  logic       wp_pin,
    output logic       acc_ack,
    output logic [7:0] acc_rdata,
    output logic       wr_blocked
);
    logic              hit_main, hit_aux, locked, unmapped;
    bank_e             bank_sel;
    logic [7:0]        bank_idx;
    logic [BYTE_W-1:0] page_sel_q, cfg_q, fixaddr_q;
    logic              commit, blocked_now;
    logic [BYTE_W-1:0] bank_rd [NUM_BANKS];

    mm_addr_decode #(
        .AUX_ADDR       (AUX_ADDR),
        .MAIN_ADDR_DFLT (MAIN_ADDR_DFLT)
    ) u_dec (
        .dev_addr (acc_dev_addr),
        .offset   (acc_offset),
        .cfg      (cfg_q),
        .fixaddr  (fixaddr_q),
        .page_sel (page_sel_q),
        .wp_pin   (wp_pin),
        .hit_main (hit_main),
        .hit_aux  (hit_aux),
        .bank     (bank_sel),
        .idx      (bank_idx),
        .locked   (locked),
        .unmapped (unmapped)
    );

    // acknowledge and write qualification
    always_comb begin
        acc_ack     = acc_valid && (hit_main || hit_aux);
        commit      = acc_ack && acc_write && !unmapped && !locked;
        blocked_now = acc_ack && acc_write && !unmapped && locked;
    end

    mm_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .wr_bank    (bank_sel),
        .wr_idx     (bank_idx),
        .wr_data    (acc_wdata),
        .page_sel_q (page_sel_q),
        .cfg_q      (cfg_q),
        .fixaddr_q  (fixaddr_q)
    );

    // one bank per storage region; the auxiliary bank is deeper
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int DEP = (g == int'(BK_AUX)) ? AUX_DEPTH : PAGE_DEPTH;
        localparam int AW  = $clog2(DEP);
        logic we;
        assign we = commit && (bank_sel == bank_e'(g));
        mm_byte_bank #(.DEPTH(DEP), .DW(BYTE_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we),
            .addr  (bank_idx[AW-1:0]),
            .wdata (acc_wdata),
            .rdata (bank_rd[g])
        );
    end

    // read data return: FFh for an unmapped page, zero when not acknowledged
    always_comb begin
        acc_rdata = '0;
        if (acc_ack) begin
            if (unmapped || bank_sel == BK_NONE) acc_rdata = 8'hFF;
            else                                 acc_rdata = bank_rd[int'(bank_sel)];
        end
    end

    // one-cycle flag after a blocked write
    always_ff @(posedge clk) begin
        if (!rst_n) wr_blocked <= 1'b0;
        else        wr_blocked <= blocked_now;
    end
endmodule

// File: rtl/mm_checker.sv
`timescale 1ns/1ps
// Module: mm_checker
// Temporal checks on the byte map, bound into every instance of the top.
module mm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       acc_write,
    input logic       acc_ack,
    input logic [7:0] acc_offset,
    input logic       wp_pin,
    input logic       wr_blocked,
    input logic       hit_main,
    input logic       hit_aux,
    input logic [7:0] cfg_q
);
    a_r1_ack_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_ack);

    a_r11_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> $past(acc_valid && acc_write && acc_ack));

    a_r10_scratch_open: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && hit_main && acc_offset >= 8'h60 && acc_offset <= 8'h7F)
        |=> !wr_blocked);

    a_r8_aux_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && hit_aux && cfg_q[1]) |=> wr_blocked);

    a_r7_pin_low_open: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && hit_main && !wp_pin && !cfg_q[1]) |=> !wr_blocked);

    a_r6_single_mutes_aux: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[2] |-> !hit_aux);
endmodule

bind dual_addr_memmap mm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_ack    (acc_ack),
    .acc_offset (acc_offset),
    .wp_pin     (wp_pin),
    .wr_blocked (wr_blocked),
    .hit_main   (hit_main),
    .hit_aux    (hit_aux),
    .cfg_q      (cfg_q)
);

// File: tb/dual_addr_memmap_test.sv
`timescale 1ns/1ps
module dual_addr_memmap_test;
    localparam logic [6:0] AUX = 7'h50;
    localparam logic [6:0] PRI = 7'h51;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [6:0] acc_dev_addr = '0;
    logic [7:0] acc_offset = '0;
    logic       acc_write = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic       wp_pin = 1'b0;
    logic       acc_ack;
    logic [7:0] acc_rdata;
    logic       wr_blocked;

    int n_cmp = 0;
    int n_bad = 0;
    logic       r_ack, r_blk;
    logic [7:0] r_dat;

    always #10 clk = ~clk;

    dual_addr_memmap uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_dev_addr(acc_dev_addr),
        .acc_offset(acc_offset), .acc_write(acc_write), .acc_wdata(acc_wdata),
        .wp_pin(wp_pin), .acc_ack(acc_ack), .acc_rdata(acc_rdata), .wr_blocked(wr_blocked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one access: ack/rdata sampled mid-cycle, flag sampled after the edge
    task automatic acc(input logic [6:0] d, input logic [7:0] o, input logic w, input logic [7:0] v);
        @(negedge clk);
        acc_valid = 1'b1; acc_dev_addr = d; acc_offset = o; acc_write = w; acc_wdata = v;
        #5;
        r_ack = acc_ack; r_dat = acc_rdata;
        @(posedge clk); #1;
        r_blk = wr_blocked;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic wr(input logic [6:0] d, input logic [7:0] o, input logic [7:0] v);
        acc(d, o, 1'b1, v);
    endtask

    task automatic rd(input logic [6:0] d, input logic [7:0] o);
        acc(d, o, 1'b0, 8'h00);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state
        chk("R12 flag", wr_blocked, 0);
        rd(PRI, 8'h00); chk("R12 low", r_dat, 8'h00);
        rd(PRI, 8'h7F); chk("R12 sel", r_dat, 8'h00);
        rd(AUX, 8'hC3); chk("R12 aux", r_dat, 8'h00);
        // R5 select 00 without single mode is unmapped
        rd(PRI, 8'h80); chk("R5 sel00 ff", r_dat, 8'hFF);
        chk("R5 ack", r_ack, 1);

        // R4 full auxiliary sweep
        for (int i = 0; i < 256; i++) wr(AUX, 8'(i), 8'((i * 7 + 3) & 8'hFF));
        for (int i = 0; i < 256; i++) begin
            rd(AUX, 8'(i)); chk("R4 aux", r_dat, 8'((i * 7 + 3) & 8'hFF));
        end
        // R3 window 03 onto auxiliary lower half
        wr(PRI, 8'h7F, 8'h03);
        for (int k = 0; k < 128; k++) begin
            rd(PRI, 8'(8'h80 + k)); chk("R3 win", r_dat, 8'((k * 7 + 3) & 8'hFF));
        end
        // R3 pages 02 and 01 must not alias
        wr(PRI, 8'h7F, 8'h02);
        for (int k = 0; k < 128; k++) wr(PRI, 8'(8'h80 + k), 8'(k) ^ 8'hA5);
        wr(PRI, 8'h7F, 8'h01);
        for (int k = 0; k < 128; k++)
            if (k != 9 && k != 12) wr(PRI, 8'(8'h80 + k), 8'(k) ^ 8'h3C);
        for (int k = 0; k < 128; k++)
            if (k != 9 && k != 12) begin
                rd(PRI, 8'(8'h80 + k)); chk("R3 p01", r_dat, 8'(k) ^ 8'h3C);
            end
        wr(PRI, 8'h7F, 8'h02);
        for (int k = 0; k < 128; k++) begin
            rd(PRI, 8'(8'h80 + k)); chk("R3 p02", r_dat, 8'(k) ^ 8'hA5);
        end

        // R5 unmapped select 07h
        wr(PRI, 8'h7F, 8'h07);
        rd(PRI, 8'h85); chk("R5 rd ff", r_dat, 8'hFF);
        wr(PRI, 8'h85, 8'h11); chk("R5 ack", r_ack, 1); chk("R5 noflag", r_blk, 0);
        wr(PRI, 8'h7F, 8'h02);
        rd(PRI, 8'h85); chk("R5 p02 kept", r_dat, 8'h05 ^ 8'hA5);

        // R1 address sweep
        for (int d = 0; d < 128; d++) begin
            rd(7'(d), 8'h00);
            chk("R1 ack", r_ack, (d == 8'h50 || d == 8'h51) ? 1 : 0);
            if (d != 8'h50 && d != 8'h51) chk("R1 rdata", r_dat, 8'h00);
        end
        wr(7'h52, 8'h10, 8'h77); chk("R1 nak wr", r_ack, 0);
        rd(PRI, 8'h10); chk("R1 untouched", r_dat, 8'h00);

        // R2 moved primary address (B4h -> 5Ah)
        wr(PRI, 8'h7F, 8'h01);
        wr(PRI, 8'h8C, 8'hB4);
        wr(PRI, 8'h89, 8'h08);
        rd(PRI, 8'h00); chk("R2 old nak", r_ack, 0);
        rd(7'h5A, 8'h8C); chk("R2 new ack", r_ack, 1); chk("R2 byte", r_dat, 8'hB4);
        wr(7'h5A, 8'h89, 8'h00);
        rd(PRI, 8'h00); chk("R2 back", r_ack, 1);

        // R6..R11 protection truth table
        for (int c = 0; c < 16; c++) begin
            logic pin, mp, ap, sg;
            logic eb;
            pin = c[0]; mp = c[1]; ap = c[2]; sg = c[3];
            wp_pin = 1'b0;
            wr(PRI, 8'h7F, 8'h01); wr(PRI, 8'h89, 8'h00);
            wr(PRI, 8'h10, 8'hA0); wr(PRI, 8'h65, 8'hA1); wr(PRI, 8'hA0, 8'hA2);
            wr(AUX, 8'h30, 8'hA3);
            wr(PRI, 8'h89, 8'h04); wr(PRI, 8'h7F, 8'h00); wr(PRI, 8'h90, 8'hA4);
            wr(PRI, 8'h7F, 8'h01);
            wr(PRI, 8'h89, {5'b0, sg, ap, mp});
            wp_pin = pin;

            eb = pin & mp;
            wr(PRI, 8'h10, 8'hB0); chk("R7 low flag", r_blk, eb); chk("R11 ack", r_ack, 1);
            rd(PRI, 8'h10); chk("R11 low data", r_dat, eb ? 8'hA0 : 8'hB0);
            @(negedge clk); chk("R11 one cycle", wr_blocked, 0);
            wr(PRI, 8'h65, 8'hB1); chk("R10 flag", r_blk, 0);
            rd(PRI, 8'h65); chk("R10 data", r_dat, 8'hB1);
            wr(PRI, 8'hA0, 8'hB2); chk("R7 p01 flag", r_blk, eb);
            rd(PRI, 8'hA0); chk("R7 p01 data", r_dat, eb ? 8'hA2 : 8'hB2);
            if (sg) begin
                wr(PRI, 8'h7F, 8'h00);
                wr(PRI, 8'h90, 8'hB4); chk("R9 p00 flag", r_blk, ap);
                rd(PRI, 8'h90); chk("R9 p00 data", r_dat, ap ? 8'hA4 : 8'hB4);
            end
            wr(AUX, 8'h30, 8'hB3);
            chk("R6 aux ack", r_ack, sg ? 0 : 1);
            chk("R8 aux flag", r_blk, (!sg) & ap);
            wr(PRI, 8'h7F, 8'h03);
            rd(PRI, 8'hB0); chk("R8 aux data", r_dat, (sg | ap) ? 8'hA3 : 8'hB3);

            wp_pin = 1'b0;
            wr(PRI, 8'h7F, 8'h01); wr(PRI, 8'h89, 8'h00);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule